// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Loader

This block holds the two threshold offsets that a FIFO's programmable flag logic compares against: the almost-empty offset and the almost-full offset. Each offset is OFS_W bits wide and is stored as byte-sized slices. The logic that compares flags against these offsets is not part of this block; it uses the two offset outputs.

Software or a board controller can fill the offsets in one of two ways. The way is chosen by the `sel_serial` pin, which is sampled only while master reset is held. That choice also sets the value the offsets take at reset. In serial mode, one bit enters per write-clock edge under a serial enable. In parallel mode, one data byte enters per write-clock edge under a load strobe with write enable. A separate pointer in the read-clock domain steps through the same bytes, so the stored offsets can be read back on a byte-wide output whichever loading mode is active.

Master reset is synchronous and is sampled on both clocks. It must be held for at least one edge of each clock.

Top module: `flag_offset_prog`

## Requirements
- R1: While `mrst` is high, a write-clock edge sets both offsets to the default for the selected mode: 1023 when `sel_serial`=1 and 127 when `sel_serial`=0. A read-clock edge in that state clears `rd_q` to 0.
- R2: In serial mode, each write-clock edge with `sen`=1 stores `sin` into the next bit of a 2*OFS_W-bit chain. The chain starts at bit 0 of the almost-empty offset, runs up to its top bit, continues from bit 0 of the almost-full offset, and wraps back to almost-empty bit 0 after the last bit.
- R3: In parallel mode, each write-clock edge with `ld`=1 and `wen`=1 stores `din` into the next byte slot. The slot order is almost-empty low byte (slot 0), almost-empty high byte (slot 1), almost-full low byte (slot 2) and almost-full high byte (slot 3), and the order wraps from slot 3 to slot 0.
- R4: In serial mode, `ld`/`wen` writes leave both offsets unchanged. In parallel mode, `sen` leaves both offsets unchanged.
- R5: Each read-clock edge with `ld`=1 and `ren`=1 loads `rd_q` with the next slot in the R3 order, using a readback pointer separate from the write pointer. The first such edge after reset gives slot 0, the second gives slot 1, and the order wraps. On any other edge, `rd_q` holds its value.
- R6: Readback works in serial mode exactly as it does in parallel mode.
- R7: `wen` without `ld` changes no offset, and `ren` without `ld` changes neither `rd_q` nor the readback pointer.
- R8: Master reset returns both the write slot pointer and the readback pointer to slot 0. The serial bit position also returns to 0. A change on `sel_serial` while reset is low has no effect on the mode.
- R9: When a parallel write and a readback of the same slot fall on one shared clock edge, `rd_q` shows the value the slot held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; loads offsets |
| rclk | input | 1 | Read clock; drives readback |
| mrst | input | 1 | Synchronous master reset, active high |
| sel_serial | input | 1 | Mode select sampled during reset: 1 serial, 0 parallel |
| ld | input | 1 | Load strobe for parallel write and readback |
| sen | input | 1 | Serial shift enable |
| sin | input | 1 | Serial data bit |
| wen | input | 1 | Write enable for parallel load |
| ren | input | 1 | Read enable for readback |
| din | input | BYTE_W | Parallel data byte |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| rd_q | output | BYTE_W | Readback byte |

## Verification
A parallel byte write and a readback can fall on the same edge when the two clocks are aligned. The bench drives both clock ports from one clock. It then asserts `ld`, `wen` and `ren` together at a moment when both pointers address the same slot. The check passes only if `rd_q` shows the slot's old byte while the offset output already shows the new byte one edge later.

// File: rtl/flag_offset_prog.sv
module flag_offset_prog #(
  parameter int BYTE_W  = 8,
  parameter int OFS_W   = 16,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              sel_serial,
  input  logic              ld,
  input  logic              sen,
  input  logic              sin,
  input  logic              wen,
  input  logic              ren,
  input  logic [BYTE_W-1:0] din,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic [BYTE_W-1:0] rd_q
);
  localparam int NB   = OFS_W / BYTE_W;
  localparam int NREG = 2 * NB;
  localparam int TOT  = NREG * BYTE_W;
  localparam int PW   = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int SW   = $clog2(TOT);
  localparam logic [OFS_W-1:0] DP = OFS_W'(DEF_PAR);
  localparam logic [OFS_W-1:0] DS = OFS_W'(DEF_SER);

  logic [TOT-1:0] ofs_q;
  logic           mode_ser;
  logic [PW-1:0]  wptr;
  logic [PW-1:0]  rptr;
  logic [SW-1:0]  sbit;

  assign ae_ofs = ofs_q[OFS_W-1:0];
  assign af_ofs = ofs_q[TOT-1:OFS_W];

  always_ff @(posedge wclk) begin
    if (mrst) begin
      mode_ser <= sel_serial;
      ofs_q    <= sel_serial ? {DS, DS} : {DP, DP};
      wptr     <= '0;
      sbit     <= '0;
    end else if (mode_ser) begin
      if (sen) begin
        ofs_q[sbit] <= sin;
        sbit        <= (sbit == SW'(TOT-1)) ? '0 : sbit + 1'b1;
      end
    end else if (ld && wen) begin
      ofs_q[int'(wptr)*BYTE_W +: BYTE_W] <= din;
      wptr <= (wptr == PW'(NREG-1)) ? '0 : wptr + 1'b1;
    end
  end

  always_ff @(posedge rclk) begin
    if (mrst) begin
      rptr <= '0;
      rd_q <= '0;
    end else if (ld && ren) begin
      rd_q <= ofs_q[int'(rptr)*BYTE_W +: BYTE_W];
      rptr <= (rptr == PW'(NREG-1)) ? '0 : rptr + 1'b1;
    end
  end
endmodule

// File: rtl/flag_offset_prog_chk.sv
module flag_offset_prog_chk #(
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 16
) (
  input logic              wclk,
  input logic              rclk,
  input logic              mrst,
  input logic              mode_ser,
  input logic              ld,
  input logic              sen,
  input logic              wen,
  input logic              ren,
  input logic [OFS_W-1:0]  ae_ofs,
  input logic [OFS_W-1:0]  af_ofs,
  input logic [BYTE_W-1:0] rd_q
);
  AST_RDQ_HOLD: assert property (@(posedge rclk) disable iff (mrst)
    !(ld && ren) |=> $stable(rd_q)); // R5

  AST_PAR_NO_SHIFT: assert property (@(posedge wclk) disable iff (mrst)
    (!mode_ser && !(ld && wen)) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R4

  AST_SER_NO_IDLE: assert property (@(posedge wclk) disable iff (mrst)
    (mode_ser && !sen) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R4

  AST_SER_ONE_BIT: assert property (@(posedge wclk) disable iff (mrst)
    (mode_ser && sen) |=> ($countones({ae_ofs, af_ofs} ^ $past({ae_ofs, af_ofs})) <= 1)); // R2

  AST_PAR_ONE_OFS: assert property (@(posedge wclk) disable iff (mrst)
    (!mode_ser && ld && wen) |=> ($stable(ae_ofs) || $stable(af_ofs))); // R3

  AST_MODE_FIXED: assert property (@(posedge wclk) disable iff (mrst)
    1'b1 |=> $stable(mode_ser)); // R8
endmodule

bind flag_offset_prog flag_offset_prog_chk #(.BYTE_W(BYTE_W), .OFS_W(OFS_W)) chk_i (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .mode_ser(mode_ser), .ld(ld),
  .sen(sen), .wen(wen), .ren(ren), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_q(rd_q)
);

// File: tb/flag_offset_prog_tb_top.sv
module flag_offset_prog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // fields: ld wen ren sen sin | din | exp ae | exp af | exp rd_q  (parallel mode)
  localparam logic [52:0] TBL [NV] = '{
    {5'b11000, 8'h34, 16'h0034, 16'h007F, 8'h00},  // R3 slot 0
    {5'b11000, 8'h12, 16'h1234, 16'h007F, 8'h00},  // R3 slot 1
    {5'b01000, 8'hFF, 16'h1234, 16'h007F, 8'h00},  // R7 wen alone
    {5'b11000, 8'hCD, 16'h1234, 16'h00CD, 8'h00},  // R3 slot 2
    {5'b11000, 8'hAB, 16'h1234, 16'hABCD, 8'h00},  // R3 slot 3
    {5'b11000, 8'h99, 16'h1299, 16'hABCD, 8'h00},  // R3 wrap
    {5'b10100, 8'h00, 16'h1299, 16'hABCD, 8'h99},  // R5 first read
    {5'b10100, 8'h00, 16'h1299, 16'hABCD, 8'h12},  // R5 second = ae high
    {5'b00100, 8'h00, 16'h1299, 16'hABCD, 8'h12},  // R7 ren alone
    {5'b10100, 8'h00, 16'h1299, 16'hABCD, 8'hCD},  // R5
    {5'b10100, 8'h00, 16'h1299, 16'hABCD, 8'hAB},  // R5
    {5'b10100, 8'h00, 16'h1299, 16'hABCD, 8'h99},  // R5 wrap
    {5'b11100, 8'h55, 16'h5599, 16'hABCD, 8'h12},  // R9 same edge
    {5'b10100, 8'h00, 16'h5599, 16'hABCD, 8'hCD},  // R5
    {5'b00011, 8'h00, 16'h5599, 16'hABCD, 8'hCD}   // R4 sen in parallel mode
  };

  logic clk = 0, mrst = 1, sel_serial = 0;
  logic ld = 0, sen = 0, sin = 0, wen = 0, ren = 0;
  logic [7:0] din = 0;
  logic [15:0] ae_ofs, af_ofs;
  logic [7:0] rd_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_offset_prog dut_i (
    .wclk(clk), .rclk(clk), .mrst(mrst), .sel_serial(sel_serial), .ld(ld),
    .sen(sen), .sin(sin), .wen(wen), .ren(ren), .din(din),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs), .rd_q(rd_q)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic l, logic w, logic r, logic s, logic b, logic [7:0] d);
    ld = l; wen = w; ren = r; sen = s; sin = b; din = d;
    @(negedge clk);
    ld = 0; wen = 0; ren = 0; sen = 0; sin = 0;
  endtask

  task automatic do_reset(logic ser);
    @(negedge clk);
    sel_serial = ser; mrst = 1;
    repeat (3) @(negedge clk);
    mrst = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset(1'b0);
    check("R1 parallel defaults", {ae_ofs, af_ofs, rd_q}, {16'd127, 16'd127, 8'h00});
    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = TBL[i];
      drive(v[52], v[51], v[50], v[49], v[48], v[47:40]);
      check($sformatf("vector %0d (R3 R4 R5 R7 R9)", i),
            {ae_ofs, af_ofs, rd_q}, {v[39:24], v[23:8], v[7:0]});
    end

    do_reset(1'b1);
    check("R1 serial defaults", {ae_ofs, af_ofs, rd_q}, {16'd1023, 16'd1023, 8'h00});
    drive(1, 0, 1, 0, 0, 8'h00);
    check("R8 R6 readback slot 0 after reset", rd_q, 8'hFF);
    drive(1, 0, 1, 0, 0, 8'h00);
    check("R5 second read ae high", rd_q, 8'h03);
    for (int b = 0; b < 16; b++) drive(0, 0, 0, 1, 16'hA5C3 >> b, 8'h00);
    check("R2 ae filled serially", {ae_ofs, af_ofs}, {16'hA5C3, 16'h03FF});
    for (int b = 0; b < 16; b++) drive(0, 0, 0, 1, 16'h0F0F >> b, 8'h00);
    check("R2 af filled serially", {ae_ofs, af_ofs}, {16'hA5C3, 16'h0F0F});
    drive(0, 0, 0, 1, 0, 8'h00);
    check("R2 chain wraps to ae bit 0", ae_ofs, 16'hA5C2);
    drive(1, 1, 0, 0, 0, 8'h77);
    check("R4 parallel write ignored in serial", {ae_ofs, af_ofs}, {16'hA5C2, 16'h0F0F});
    sel_serial = 0;
    drive(0, 0, 0, 1, 0, 8'h00);
    check("R8 mode kept without reset", ae_ofs, 16'hA5C0);
    drive(1, 0, 1, 0, 0, 8'h00);
    check("R6 readback in serial mode", rd_q, 8'h0F);

    do_reset(1'b0);
    check("R1 rd_q cleared", rd_q, 8'h00);
    drive(1, 0, 1, 0, 0, 8'h00);
    check("R8 readback pointer reset", rd_q, 8'h7F);
    drive(1, 1, 0, 0, 0, 8'h3C);
    check("R8 write pointer reset", {ae_ofs, af_ofs}, {16'h003C, 16'h007F});
    finish_run();
  end
endmodule